// File: doc/BRIEF.md
# RTC Interrupt and Square-Wave Unit

This unit sits next to a real-time clock's timekeeping counters. It turns a 32.768 kHz clock-enable pulse and an end-of-update strobe from the timekeeper into three sticky event flags. The periodic flag comes from a programmable divider. The alarm flag is set when the current second, minute and hour match the alarm settings. The update flag is set each time the timekeeper finishes an update. Each flag has its own enable. An active-low interrupt request is asserted while any enabled flag is set.

The divider chain that paces the periodic flag also drives the square-wave pin, so both always run at the same rate. Any alarm byte can be made a wildcard. This lets the alarm fire once a second, once a minute, once an hour or once a day. The host reads the flag byte through a one-cycle read strobe, and that read clears every flag.

Top module: `rtc_irq_unit`

## Requirements
- R1: `flag_out` layout: bit 7 is the interrupt summary (1 when `irq_n` is low), bit 6 the periodic flag, bit 5 the alarm flag, bit 4 the update flag. Bits 3 to 0 read 0.
- R2: The divider counts `tick_32k` pulses from 0 after reset. For a rate code r, the period P is 2^(r-1) ticks for r = 3..15, 128 ticks for r = 1 and 256 ticks for r = 2. The periodic flag is set on the tick that brings the tick count to a multiple of P.
- R3: Rate code 0 never sets the periodic flag and holds `sqw` low.
- R4: With `sqw_en` high and a nonzero rate code, `sqw` equals bit (log2 P − 1) of the tick count. This gives a square wave at the periodic frequency. With `sqw_en` low, `sqw` is low from the next cycle onwards.
- R5: An `upd_done` pulse sets the update flag.
- R6: During an `upd_done` pulse, the alarm flag is set when each of second, minute and hour either equals its alarm byte or has an alarm byte whose bits 7:6 are 2'b11. An alarm byte with only bit 7 set is compared normally.
- R7: Flags stay set until read. A `flag_rd` cycle returns the current flags and clears all of them on the next cycle.
- R8: An event that arrives in the same cycle as a read is not lost. The read returns the old value and the new flag stays set afterwards.
- R9: Flags are set whatever their enables are. `irq_n` is low exactly when some flag is set together with its enable (`per_ie`, `alm_ie`, `upd_ie`).
- R10: After reset all flags are clear, `irq_n` is high, `sqw` is low and the divider is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| rate_sel | input | 4 | Periodic/square-wave rate code |
| sqw_en | input | 1 | Square-wave output enable |
| per_ie | input | 1 | Periodic flag interrupt enable |
| alm_ie | input | 1 | Alarm flag interrupt enable |
| upd_ie | input | 1 | Update flag interrupt enable |
| upd_done | input | 1 | End-of-update strobe from timekeeper |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hr | input | 8 | Alarm hours |
| flag_rd | input | 1 | Flag byte read strobe |
| flag_out | output | 8 | Flag byte with interrupt summary |
| irq_n | output | 1 | Active-low interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The bench tests the irregular rate codes 1 and 2, the slowest code 15 and code 0. A design that maps the rate codes linearly would set the periodic flag at the wrong tick or would go on running when code 0 is selected. Alarm tests use the full wildcard, a single-field wildcard and a byte with only bit 7 set. A design that decodes the wildcard from one bit would fire on that last case. The bench also issues a read in the same cycle as an update strobe. A design that gives the clear priority would lose that event. Interrupt tests leave a flag set while its enable is off, to catch a design that gates the flags instead of the request.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NUM_EVT = 3;
    localparam int EVT_PER = 2;
    localparam int EVT_ALM = 1;
    localparam int EVT_UPD = 0;

    // log2 of the period in ticks for a rate code; 0 means off
    function automatic logic [3:0] rate_shift(input logic [3:0] code);
        case (code)
            4'd0:    rate_shift = 4'd0;
            4'd1:    rate_shift = 4'd7;
            4'd2:    rate_shift = 4'd8;
            default: rate_shift = code - 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
    import rtc_irq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    output logic       per_evt,
    output logic       sqw
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sqw;
    } div_t;

    div_t             div_d, div_q;
    logic [3:0]       shift;
    logic [CNT_W-1:0] mask;
    logic             run;

    always_comb begin
        shift   = rate_shift(rate_sel);
        mask    = (CNT_W'(1) << shift) - CNT_W'(1);
        run     = (rate_sel != 4'd0);
        div_d   = div_q;
        per_evt = 1'b0;
        if (tick) begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
            if (run && ((div_q.cnt & mask) == mask))
                per_evt = 1'b1;
        end
        if (sqw_en && run)
            div_d.sqw = div_d.cnt[shift - 4'd1];
        else
            div_d.sqw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else
            div_q <= div_d;
    end

    assign sqw = div_q.sqw;

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FIELDS = 3,
    parameter int W      = 8
) (
    input  logic [FIELDS-1:0][W-1:0] cur,
    input  logic [FIELDS-1:0][W-1:0] alm,
    output logic                     hit
);

    logic [FIELDS-1:0] fld_ok;

    for (genvar i = 0; i < FIELDS; i++) begin : g_fld
        assign fld_ok[i] = (alm[i][W-1 -: 2] == 2'b11) || (alm[i] == cur[i]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] ena,
    input  logic         rd,
    output logic [N-1:0] flags,
    output logic         irq_n
);

    typedef struct packed {
        logic [N-1:0] flg;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.flg = (rd ? '0 : fl_q.flg) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fl_q <= '0;
        else
            fl_q <= fl_d;
    end

    assign flags = fl_q.flg;
    assign irq_n = ~|(fl_q.flg & ena);

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [3:0]        rate_sel,
    input  logic              sqw_en,
    input  logic              per_ie,
    input  logic              alm_ie,
    input  logic              upd_ie,
    input  logic              upd_done,
    input  logic [TIME_W-1:0] cur_sec,
    input  logic [TIME_W-1:0] cur_min,
    input  logic [TIME_W-1:0] cur_hr,
    input  logic [TIME_W-1:0] alm_sec,
    input  logic [TIME_W-1:0] alm_min,
    input  logic [TIME_W-1:0] alm_hr,
    input  logic              flag_rd,
    output logic [7:0]        flag_out,
    output logic              irq_n,
    output logic              sqw
);

    localparam int FIELDS = 3;

    logic                          per_evt;
    logic                          alm_hit;
    logic [NUM_EVT-1:0]            evt;
    logic [NUM_EVT-1:0]            ena;
    logic [NUM_EVT-1:0]            flags;
    logic [FIELDS-1:0][TIME_W-1:0] cur_v;
    logic [FIELDS-1:0][TIME_W-1:0] alm_v;

    assign cur_v = {cur_hr, cur_min, cur_sec};
    assign alm_v = {alm_hr, alm_min, alm_sec};

    rtc_rate_div #(.CNT_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .per_evt  (per_evt),
        .sqw      (sqw)
    );

    rtc_alarm_cmp #(.FIELDS(FIELDS), .W(TIME_W)) u_alm (
        .cur (cur_v),
        .alm (alm_v),
        .hit (alm_hit)
    );

    always_comb begin
        evt          = '0;
        evt[EVT_PER] = per_evt;
        evt[EVT_ALM] = upd_done & alm_hit;
        evt[EVT_UPD] = upd_done;
        ena          = '0;
        ena[EVT_PER] = per_ie;
        ena[EVT_ALM] = alm_ie;
        ena[EVT_UPD] = upd_ie;
    end

    rtc_flag_reg #(.N(NUM_EVT)) u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .ena   (ena),
        .rd    (flag_rd),
        .flags (flags),
        .irq_n (irq_n)
    );

    assign flag_out = {~irq_n, flags[EVT_PER], flags[EVT_ALM], flags[EVT_UPD], 4'b0000};

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic [3:0] rate_sel,
    input logic       sqw_en,
    input logic       upd_ie,
    input logic       upd_done,
    input logic       flag_rd,
    input logic [7:0] flag_out,
    input logic       irq_n,
    input logic       sqw
);

    // R5
    upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flag_out[4]);

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !upd_done && !tick_32k) |=> (flag_out[6:4] == 3'b000));

    // R7
    alm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_rd && flag_out[5]) |=> flag_out[5]);

    // R6
    alm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !flag_out[5]) |=> !flag_out[5]);

    // R9
    irq_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out[4] && upd_ie) |-> !irq_n);

    // R3
    rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0 && !flag_out[6]) |=> !flag_out[6]);

    // R4
    sqw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw);

endmodule

bind rtc_irq_unit rtc_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_32k (tick_32k),
    .rate_sel (rate_sel),
    .sqw_en   (sqw_en),
    .upd_ie   (upd_ie),
    .upd_done (upd_done),
    .flag_rd  (flag_rd),
    .flag_out (flag_out),
    .irq_n    (irq_n),
    .sqw      (sqw)
);

// File: tb/sim_rtc_irq_unit.sv
module sim_rtc_irq_unit;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       sqw_en = 1'b0;
    logic       per_ie = 1'b0, alm_ie = 1'b0, upd_ie = 1'b0;
    logic       upd_done = 1'b0;
    logic [7:0] cur_sec = 8'h56, cur_min = 8'h34, cur_hr = 8'h12;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic       flag_rd = 1'b0;
    logic [7:0] flag_out;
    logic       irq_n;
    logic       sqw;

    int n_run = 0;
    int n_fail = 0;
    int tc = 0;
    logic m_pf = 1'b0, m_af = 1'b0, m_uf = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    rtc_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .sqw_en(sqw_en), .per_ie(per_ie), .alm_ie(alm_ie), .upd_ie(upd_ie),
        .upd_done(upd_done), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr), .flag_rd(flag_rd),
        .flag_out(flag_out), .irq_n(irq_n), .sqw(sqw)
    );

    function automatic int shift_of(input int r);
        if (r == 1) return 7;
        if (r == 2) return 8;
        return r - 1;
    endfunction

    function automatic logic [7:0] model_byte();
        logic irq;
        irq = (m_pf & per_ie) | (m_af & alm_ie) | (m_uf & upd_ie);
        return {irq, m_pf, m_af, m_uf, 4'b0000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read values while a read is on the bus
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (flag_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, flag_out, e);
        end
    end

    task automatic do_read(input string req);
        @(negedge clk);
        exp_q.push_back(model_byte());
        tag_q.push_back(req);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
        m_pf = 1'b0; m_af = 1'b0; m_uf = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        int r;
        r = rate_sel;
        @(negedge clk);
        tick_32k = 1'b1;
        repeat (n) @(negedge clk);
        tick_32k = 1'b0;
        if (r != 0 && ((tc + n) >> shift_of(r)) != (tc >> shift_of(r)))
            m_pf = 1'b1;
        tc = (tc + n) % 32768;
    endtask

    task automatic per_step(input int r, input int n, input string req);
        @(negedge clk);
        rate_sel = 4'(r);
        run_ticks(n);
        do_read(req);
    endtask

    task automatic pulse_upd();
        logic hit;
        hit = ((alm_sec[7:6] == 2'b11) || alm_sec == cur_sec) &&
              ((alm_min[7:6] == 2'b11) || alm_min == cur_min) &&
              ((alm_hr[7:6]  == 2'b11) || alm_hr  == cur_hr);
        @(negedge clk);
        upd_done = 1'b1;
        @(negedge clk);
        upd_done = 1'b0;
        m_uf = 1'b1;
        if (hit) m_af = 1'b1;
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        @(negedge clk);
        alm_sec = s; alm_min = m; alm_hr = h;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 flags", flag_out, 8'h00);
        chk("R10 irq_n", irq_n, 1);
        chk("R10 sqw", sqw, 0);

        // R2 fastest rate: period 4 ticks
        per_step(3, 3, "R2 rate3 before boundary");
        per_step(3, 1, "R2 rate3 at boundary");
        // R9 periodic interrupt with enable
        per_ie = 1'b1;
        @(negedge clk);
        rate_sel = 4'd3;
        run_ticks(4);
        chk("R9 irq_n low periodic", irq_n, 0);
        do_read("R1 R9 periodic with summary");
        chk("R9 irq_n released after read", irq_n, 1);
        per_ie = 1'b0;

        // R4 square wave follows tick count bit
        @(negedge clk);
        sqw_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            run_ticks(1);
            chk("R4 sqw rate3", sqw, (tc >> 1) & 1);
        end
        @(negedge clk);
        rate_sel = 4'd6;
        for (int i = 0; i < 6; i++) begin
            run_ticks(7);
            chk("R4 sqw rate6", sqw, (tc >> 4) & 1);
        end
        @(negedge clk);
        sqw_en = 1'b0;
        @(negedge clk);
        chk("R4 sqw disabled", sqw, 0);
        do_read("R2 clear after sqw run");

        // R2 irregular and slow codes
        per_step(1, 50, "R2 rate1 short");
        per_step(1, 200, "R2 rate1 long");
        per_step(2, 100, "R2 rate2 short");
        per_step(2, 300, "R2 rate2 long");
        per_step(6, 5, "R2 rate6 short");
        per_step(15, 16000, "R2 rate15 long");

        // R3 rate zero
        @(negedge clk);
        sqw_en = 1'b1;
        per_step(0, 100, "R3 rate0 no periodic");
        chk("R3 sqw low at rate0", sqw, 0);
        @(negedge clk);
        sqw_en = 1'b0;

        // R5 R6 alarm matching
        alm_ie = 1'b1;
        set_alarm(8'h56, 8'h34, 8'h12);
        pulse_upd();
        chk("R9 irq_n alarm", irq_n, 0);
        do_read("R6 exact match");
        set_alarm(8'h57, 8'h34, 8'h12);
        pulse_upd();
        do_read("R5 R6 mismatch seconds");
        set_alarm(8'h56, 8'h34, 8'hC0);
        pulse_upd();
        do_read("R6 hour wildcard");
        set_alarm(8'hFF, 8'hFF, 8'hFF);
        pulse_upd();
        do_read("R6 full wildcard");
        set_alarm(8'h56, 8'h34, 8'h80);
        pulse_upd();
        do_read("R6 bit7 only not wildcard");
        alm_ie = 1'b0;

        // R9 update enable only, alarm masked
        upd_ie = 1'b1;
        set_alarm(8'hFF, 8'hFF, 8'hFF);
        pulse_upd();
        do_read("R9 update enable only");
        upd_ie = 1'b0;

        // R7 sticky, then cleared
        pulse_upd();
        repeat (5) @(negedge clk);
        do_read("R7 sticky flags");
        do_read("R7 cleared after read");

        // R8 event coincident with read
        set_alarm(8'h00, 8'h00, 8'h00);
        pulse_upd();
        @(negedge clk);
        exp_q.push_back(model_byte());
        tag_q.push_back("R8 read during update");
        flag_rd = 1'b1;
        upd_done = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
        upd_done = 1'b0;
        m_pf = 1'b0; m_af = 1'b0; m_uf = 1'b1;
        do_read("R8 update flag kept");
        do_read("R8 clear");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule